// File: doc/BRIEF.md
# Zero-Suppressed Pad Sample Unpacker

This block takes a framed stream of 16-bit words that carries packed pad readout data and turns it into one sample per clock. A packet opens with an opening tag word. Two words follow that give a 32-bit byte count, low half first. Next come 64-bit pad words, each sent as four 16-bit parts with the least significant part first. The packet closes with a closing tag word. Each 64-bit pad word holds one base channel number and one time-sample index. It also holds four 10-bit values for the channels at the base, base+64, base+128 and base+192.

The unpacker drops the values that are zero. It emits each remaining value with its full 8-bit channel number and 9-bit sample index. It holds off its input while a pad word is still being emitted. At the end of each packet it gives a one-cycle marker. A sticky error flag reports a byte count that is not a whole number of pad words, a packet cut short, and stray words where the closing tag should be.

Top module: `pad_unpacker`

## Requirements
- R1: Words that arrive before the opening tag 0xCFDC are discarded. They produce no sample and no end marker.
- R2: The two words after the opening tag form the byte count, low half first. The block processes count/8 pad words, rounded down. If count[2:0] is not zero, out_err is set.
- R3: A pad word is built from four consecutive accepted words. The first of them is bits 15:0 and the last is bits 63:48.
- R4: Lane k (0..3) holds its value in bits 10k+9:10k. Its channel is c+64k, where the base channel c is bits 54:49. The sample index is bits 63:55. Bits 48:40 have no effect on any output.
- R5: A lane whose value is zero is never emitted. A pad word whose four values are all zero produces no output.
- R6: The non-zero lanes of a pad word are emitted at most one per clock, in the order base, base+64, base+128, base+192. Every sample of a pad word is emitted before any sample of the next pad word.
- R7: in_ready goes low in the cycle after the fourth part of a pad word that has a non-zero value. It stays low while that word's samples are being emitted. At all other times in_ready is high.
- R8: Once all counted pad words are taken, the closing tag 0xFFDC produces a one-cycle out_eop. out_eop never coincides with out_valid. Any other word accepted in that position is discarded and sets out_err.
- R9: If 0xFFDC arrives as the first part of a pad word before the counted words are all taken, the packet ends with out_eop and out_err is set. The pad words already completed are still emitted.
- R10: After reset, in_ready is 1 and out_valid, out_eop and out_err are 0. out_err stays set until the next opening tag is accepted, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is valid |
| in_data | input | 16 | Input word |
| in_ready | output | 1 | The block takes in_data at this edge if in_valid is high |
| out_valid | output | 1 | A sample is present on the outputs |
| out_channel | output | 8 | Channel number, from 0 to 255 |
| out_sample | output | 9 | Time-sample index |
| out_value | output | 10 | Sample value, never zero |
| out_eop | output | 1 | One-cycle end-of-packet marker |
| out_err | output | 1 | Sticky packet error flag |

## Verification
Two events can fall on the same clock edge: the closing of a packet and the raising of the error flag. A premature closing tag does both at once. Stray words in the tail slot raise the error one or more cycles before the end marker. A bad byte count raises it at the very start of the packet. The bench provokes each case with directed packets and compares out_err against its model after out_eop. It then sends a clean packet to check that the opening tag clears the flag. The emission of samples and the end marker are kept on separate cycles by the input stall, and an assertion checks that they never overlap.

// File: rtl/pad_unpack_pkg.sv
package pad_unpack_pkg;

    localparam int WORD_W   = 16;
    localparam int PARTS    = 4;
    localparam int PAD_W    = WORD_W * PARTS;
    localparam int VAL_W    = 10;
    localparam int LANES    = 4;
    localparam int LANE_W   = $clog2(LANES);
    localparam int BASE_W   = 6;
    localparam int SAMP_W   = 9;
    localparam int CHAN_W   = LANE_W + BASE_W;
    localparam int BASE_LSB = 49;
    localparam int SAMP_LSB = BASE_LSB + BASE_W;
    localparam int COUNT_W  = 2 * WORD_W;
    localparam int BYTE_SH  = $clog2(PAD_W / 8);
    localparam int REM_W    = COUNT_W - BYTE_SH;

    localparam logic [WORD_W-1:0] TAG_OPEN  = 16'hCFDC;
    localparam logic [WORD_W-1:0] TAG_CLOSE = 16'hFFDC;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CNT_LO,
        ST_CNT_HI,
        ST_BODY,
        ST_TAIL
    } frame_state_t;

    typedef struct packed {
        logic [SAMP_W-1:0]             sample;
        logic [BASE_W-1:0]             base;
        logic [LANES-1:0][VAL_W-1:0]   vals;
    } pad_word_t;

    typedef struct packed {
        logic [CHAN_W-1:0] channel;
        logic [SAMP_W-1:0] sample;
        logic [VAL_W-1:0]  value;
    } pad_sample_t;

    function automatic pad_word_t split_pad(input logic [PAD_W-1:0] w);
        pad_word_t r;
        for (int k = 0; k < LANES; k++) begin
            r.vals[k] = w[k*VAL_W +: VAL_W];
        end
        r.base   = w[BASE_LSB +: BASE_W];
        r.sample = w[SAMP_LSB +: SAMP_W];
        return r;
    endfunction

endpackage

// File: rtl/pad_word_assembler.sv
module pad_word_assembler
    import pad_unpack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              restart,
    input  logic [WORD_W-1:0] in_data,
    output logic              first_part,
    output logic              word_done,
    output logic [PAD_W-1:0]  full_word
);
    localparam int PIDX_W = $clog2(PARTS);

    logic [PIDX_W-1:0] part_idx;
    logic [PAD_W-1:0]  shreg;

    assign first_part = (part_idx == '0);
    assign word_done  = take && (part_idx == PIDX_W'(PARTS - 1));
    assign full_word  = {in_data, shreg[PAD_W-1:WORD_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            part_idx <= '0;
            shreg    <= '0;
        end else if (restart) begin
            part_idx <= '0;
        end else if (take) begin
            shreg    <= full_word;
            part_idx <= (part_idx == PIDX_W'(PARTS - 1)) ? '0 : part_idx + 1'b1;
        end
    end

    // R3: a part is taken only while a pad word is being collected, never during a restart
    assert_no_take_on_restart_R3: assert property (@(posedge clk) disable iff (rst)
        !(take && restart));

endmodule

// File: rtl/pad_lane_drain.sv
module pad_lane_drain
    import pad_unpack_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  pad_word_t   word,
    output logic        busy,
    output logic        smp_valid,
    output pad_sample_t smp
);
    pad_word_t         held;
    logic [LANES-1:0]  pending;
    logic [LANE_W-1:0] pick;

    assign busy = (pending != '0);

    always_comb begin
        pick = '0;
        for (int k = LANES - 1; k >= 0; k--) begin
            if (pending[k]) pick = LANE_W'(k);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held      <= '0;
            pending   <= '0;
            smp_valid <= 1'b0;
            smp       <= '0;
        end else begin
            smp_valid <= 1'b0;
            if (load) begin
                held <= word;
                for (int k = 0; k < LANES; k++) begin
                    pending[k] <= (word.vals[k] != '0);
                end
            end else if (busy) begin
                smp_valid     <= 1'b1;
                smp.channel   <= {pick, held.base};
                smp.sample    <= held.sample;
                smp.value     <= held.vals[pick];
                pending[pick] <= 1'b0;
            end
        end
    end

    assert_nonzero_out_R5: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> (smp.value != '0));

    assert_no_overwrite_R7: assert property (@(posedge clk) disable iff (rst)
        load |-> !busy);

    assert_emit_from_held_R6: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> $past(busy));

endmodule

// File: rtl/pad_frame_ctrl.sv
module pad_frame_ctrl
    import pad_unpack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic              busy,
    input  logic              first_part,
    input  logic              word_done,
    output logic              in_ready,
    output logic              take,
    output logic              restart,
    output logic              eop,
    output logic              err
);
    frame_state_t       state;
    logic [WORD_W-1:0]  cnt_lo;
    logic [REM_W-1:0]   remaining;
    logic [COUNT_W-1:0] full_cnt;
    logic               acc;
    logic               is_close;

    assign in_ready = !busy;
    assign acc      = in_valid && in_ready;
    assign is_close = (in_data == TAG_CLOSE);
    assign full_cnt = {in_data, cnt_lo};
    assign restart  = acc && (state == ST_IDLE) && (in_data == TAG_OPEN);
    assign take     = acc && (state == ST_BODY) && !(first_part && is_close);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt_lo    <= '0;
            remaining <= '0;
            eop       <= 1'b0;
            err       <= 1'b0;
        end else begin
            eop <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (restart) begin
                        err   <= 1'b0;
                        state <= ST_CNT_LO;
                    end
                end
                ST_CNT_LO: begin
                    if (acc) begin
                        cnt_lo <= in_data;
                        state  <= ST_CNT_HI;
                    end
                end
                ST_CNT_HI: begin
                    if (acc) begin
                        remaining <= full_cnt[COUNT_W-1:BYTE_SH];
                        if (full_cnt[BYTE_SH-1:0] != '0) err <= 1'b1;
                        state <= (full_cnt[COUNT_W-1:BYTE_SH] == '0) ? ST_TAIL : ST_BODY;
                    end
                end
                ST_BODY: begin
                    if (acc && first_part && is_close) begin
                        eop   <= 1'b1;
                        err   <= 1'b1;
                        state <= ST_IDLE;
                    end else if (word_done) begin
                        remaining <= remaining - 1'b1;
                        if (remaining == REM_W'(1)) state <= ST_TAIL;
                    end
                end
                ST_TAIL: begin
                    if (acc) begin
                        if (is_close) begin
                            eop   <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            err <= 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_body_has_work_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BODY) |-> (remaining != '0));

    assert_word_only_in_body_R9: assert property (@(posedge clk) disable iff (rst)
        word_done |-> (state == ST_BODY));

endmodule

// File: rtl/pad_unpacker.sv
module pad_unpacker
    import pad_unpack_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [15:0] in_data,
    output logic        in_ready,
    output logic        out_valid,
    output logic [7:0]  out_channel,
    output logic [8:0]  out_sample,
    output logic [9:0]  out_value,
    output logic        out_eop,
    output logic        out_err
);
    logic             take;
    logic             restart;
    logic             first_part;
    logic             word_done;
    logic             busy;
    logic [PAD_W-1:0] full_word;
    pad_sample_t      smp;

    pad_frame_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .busy       (busy),
        .first_part (first_part),
        .word_done  (word_done),
        .in_ready   (in_ready),
        .take       (take),
        .restart    (restart),
        .eop        (out_eop),
        .err        (out_err)
    );

    pad_word_assembler u_asm (
        .clk        (clk),
        .rst        (rst),
        .take       (take),
        .restart    (restart),
        .in_data    (in_data),
        .first_part (first_part),
        .word_done  (word_done),
        .full_word  (full_word)
    );

    pad_lane_drain u_drain (
        .clk       (clk),
        .rst       (rst),
        .load      (word_done),
        .word      (split_pad(full_word)),
        .busy      (busy),
        .smp_valid (out_valid),
        .smp       (smp)
    );

    assign out_channel = smp.channel;
    assign out_sample  = smp.sample;
    assign out_value   = smp.value;

    assert_eop_apart_R8: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_eop));

endmodule

// File: tb/pad_unpacker_tb.sv
module pad_unpacker_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [15:0] in_data;
    logic        in_ready;
    logic        out_valid;
    logic [7:0]  out_channel;
    logic [8:0]  out_sample;
    logic [9:0]  out_value;
    logic        out_eop;
    logic        out_err;

    always #2.5 clk = ~clk;

    pad_unpacker dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_channel(out_channel),
        .out_sample(out_sample), .out_value(out_value), .out_eop(out_eop),
        .out_err(out_err)
    );

    int n_chk = 0;
    int n_fail = 0;
    int eop_cnt = 0;
    logic [26:0] got[$];
    logic [26:0] exp_q[$];
    logic [63:0] pw[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) got.push_back({out_channel, out_sample, out_value});
            if (out_eop) eop_cnt++;
        end
    end

    function automatic void model_word(input logic [63:0] w);
        for (int k = 0; k < 4; k++) begin
            logic [9:0] v = w[k*10 +: 10];
            logic [7:0] ch = {2'(k), w[54:49]};
            if (v != 0) exp_q.push_back({ch, w[63:55], v});
        end
    endfunction

    function automatic logic [63:0] mk_word(input logic [5:0] c, input logic [8:0] s,
                                            input logic [3:0] lanes);
        logic [63:0] w = '0;
        for (int k = 0; k < 4; k++) begin
            if (lanes[k]) w[k*10 +: 10] = 10'($urandom_range(1, 1023));
        end
        w[48:40] = 9'($urandom);
        w[54:49] = c;
        w[63:55] = s;
        return w;
    endfunction

    task automatic send(input logic [15:0] w);
        in_valid = 1'b1;
        in_data  = w;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        if ($urandom_range(0, 3) == 0) @(negedge clk);
    endtask

    task automatic send_pad(input logic [63:0] w);
        for (int p = 0; p < 4; p++) begin
            in_valid = 1'b1;
            in_data  = w[p*16 +: 16];
            while (!in_ready) @(negedge clk);
            @(negedge clk);
            in_valid = 1'b0;
        end
        // R7: stall right after a word holding a non-zero value
        chk(in_ready == !(w[39:0] != 0 && (w[9:0] != 0 || w[19:10] != 0 ||
            w[29:20] != 0 || w[39:30] != 0)), "R7", "in_ready after pad word",
            in_ready, 0);
    endtask

    task automatic run_pkt(input logic [31:0] count, input int n_send,
                           input bit tail_junk, input bit exp_err, input string name);
        got.delete();
        exp_q.delete();
        eop_cnt = 0;
        for (int i = 0; i < n_send; i++) model_word(pw[i]);
        send(16'hCFDC);
        send(count[15:0]);
        send(count[31:16]);
        for (int i = 0; i < n_send; i++) send_pad(pw[i]);
        if (tail_junk) send(16'h0001);
        send(16'hFFDC);
        repeat (4) @(negedge clk);
        chk(got.size() == exp_q.size(), "R5", {name, " sample count"}, got.size(), exp_q.size());
        for (int i = 0; i < got.size() && i < exp_q.size(); i++)
            chk(got[i] == exp_q[i], "R4 R6", {name, " sample"}, got[i], exp_q[i]);
        chk(eop_cnt == 1, "R8", {name, " eop count"}, eop_cnt, 1);
        chk(out_err == exp_err, "R2 R9 R10", {name, " err"}, out_err, exp_err);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        rst = 1'b1;
        in_valid = 1'b0;
        in_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(in_ready == 1 && out_valid == 0 && out_eop == 0 && out_err == 0, "R10",
            "reset state", {in_ready, out_valid, out_eop, out_err}, 4'b1000);

        // R1: junk before opening tag
        got.delete();
        eop_cnt = 0;
        send(16'h1234);
        send(16'hFFDC);
        send(16'h0000);
        repeat (4) @(negedge clk);
        chk(got.size() == 0 && eop_cnt == 0, "R1", "junk before tag", got.size() + eop_cnt, 0);

        // R4 R6: all lanes, extreme channel and sample
        pw.delete();
        pw.push_back(mk_word(6'd63, 9'd511, 4'hF));
        pw.push_back(mk_word(6'd0, 9'd0, 4'hF));
        run_pkt(32'd16, 2, 0, 0, "full lanes");

        // R5: all-zero word and single top lane
        pw.delete();
        pw.push_back(mk_word(6'd5, 9'd7, 4'h0));
        pw.push_back(mk_word(6'd9, 9'd300, 4'h8));
        pw.push_back(mk_word(6'd1, 9'd2, 4'h2));
        run_pkt(32'd24, 3, 0, 0, "sparse");

        // R2: byte count not a multiple of 8
        pw.delete();
        pw.push_back(mk_word(6'd12, 9'd44, 4'h5));
        run_pkt(32'd11, 1, 0, 1, "odd count");

        // R10: error clears at next opening tag; zero count
        pw.delete();
        run_pkt(32'd0, 0, 0, 0, "empty");

        // R9: premature close
        pw.delete();
        pw.push_back(mk_word(6'd33, 9'd100, 4'hA));
        run_pkt(32'd24, 1, 0, 1, "premature");

        // R8: stray word in tail slot
        pw.delete();
        pw.push_back(mk_word(6'd20, 9'd60, 4'h3));
        run_pkt(32'd8, 1, 1, 1, "tail junk");

        // R3 R4 R5 R6: random packets
        for (int n = 0; n < 25; n++) begin
            int nw = $urandom_range(1, 6);
            pw.delete();
            for (int i = 0; i < nw; i++)
                pw.push_back(mk_word(6'($urandom), 9'($urandom), 4'($urandom)));
            run_pkt(32'(nw * 8), nw, 0, 0, "random");
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule